// File: doc/BRIEF.md
# Readout Sequencer Code Interpreter

This block runs a compact stored program that shapes the timing of a detector readout. A program memory holds 32-bit instruction words. A pattern memory holds timed output states. Each state has a 16-bit clock-line vector, a 4-bit control vector, a hold time in clock cycles and an end-of-pattern flag. A small lookup table gives the first pattern-memory address of each pattern number. Every output change lands on the 10 ns grid of the 100 MHz clock.

The program can play a pattern a set number of times. It can build counted loops, nested up to eight deep, and endless loops. It can call subroutines and return from them, also up to eight deep. A start pulse runs the program from address 0. Execution can be held until a rising edge arrives on an external trigger. An abort ends the run at the next pattern boundary. A reserved opcode, or a loop-stack or call-stack overflow or underflow, stops the run and raises a sticky error flag. The three memories are filled through a single write port.

Top module: `seq_interp`

## Requirements
- R1: When idle, a `start` pulse sets `busy` on the next clock edge, clears `err` and any pending abort, and begins execution at program address 0. A `start` while `busy` is high has no effect.
- R2: Opcode 001 in bits [31:29] plays a pattern. The pattern number is in bits [28:22] and the play count in bits [21:0]. The pattern's states are output in address order, from the table's start address up to and including the state with the end flag set. Each state is held for its hold time, and a hold time of 0 counts as 1. The whole pattern repeats for the play count, with no gap between repeats. A play count of 0 skips the instruction.
- R3: Every instruction other than a pattern play takes one cycle. When one pattern ends, its last state is held for its hold time, plus one cycle for each non-play instruction executed before the next play, plus two cycles.
- R4: Opcode 010 opens a counted loop whose pass count is in bits [21:0]; a count of 0 runs the body once. Opcode 011 closes the innermost loop. It jumps back to the first body instruction until all passes are done, and then falls through.
- R5: Loops nest up to 8 deep. A run that uses 8 nested loops completes without error.
- R6: Opcode 100 opens a loop that repeats its body until an abort.
- R7: Opcode 101 calls the address in bits [9:0] and saves the following address. Opcode 110 resumes at the most recently saved address.
- R8: Opcode 000 stops the run. `busy` falls, and the clock-line and control outputs hold their last values while idle.
- R9: Opcode 111, a 9th nested loop or call, a loop close with no open loop, or a return with no saved address stops the run and sets `err`. `err` stays set until the next accepted `start`.
- R10: `abort` ends a running program. During playback the run ends when the current pattern repeat finishes, so the last output is that pattern's final state. Between patterns, or while waiting for the trigger, the run ends at once.
- R11: When `trig_en` is high at start, no instruction runs until a rising edge on `trig_in`. The edge is seen after a two-stage synchronizer.
- R12: The load port writes on `ld_we`. `ld_sel` 0 writes program word `ld_data[31:0]`. `ld_sel` 1 writes a pattern state laid out as {end flag [36], control [35:32], clock lines [31:16], hold time [15:0]}. `ld_sel` 2 writes a table entry, with the start address in `ld_data[7:0]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 100 MHz clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_we | input | 1 | Memory write strobe |
| ld_sel | input | 2 | Target memory: 0 program, 1 pattern, 2 table |
| ld_addr | input | 10 | Write address |
| ld_data | input | 37 | Write data |
| start | input | 1 | Start pulse |
| abort | input | 1 | Abort request |
| trig_en | input | 1 | Hold execution for the trigger |
| trig_in | input | 1 | Asynchronous trigger input |
| clk_lines | output | 16 | Clock-line state vector |
| ctl_out | output | 4 | Control output vector |
| busy | output | 1 | Program running or waiting for the trigger |
| err | output | 1 | Sticky error flag |

## Verification
A mixed program with repeated plays, a counted loop and a subroutine call is checked state by state against expected values and hold times. This shows whether repeats run without a gap, whether a zero hold time counts as one cycle, and how many cycles each instruction between patterns adds. An eight-deep nest whose counts include 0 is checked by counting how often one state appears, which separates correct nesting and zero-count handling from an early exit. Further runs use an endless loop, single faulty programs and trigger-gated programs. These show where an abort takes effect, that each fault sets the error flag, and that nothing runs before the trigger edge.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int INSTR_W = 32;
  localparam int PNUM_W  = 7;
  localparam int REP_W   = 22;
  localparam int TGT_W   = 10;

  typedef enum logic [2:0] {
    OP_STOP = 3'd0,
    OP_EXEC = 3'd1,
    OP_LOOP = 3'd2,
    OP_LEND = 3'd3,
    OP_LINF = 3'd4,
    OP_JSR  = 3'd5,
    OP_RET  = 3'd6,
    OP_RSVD = 3'd7
  } op_e;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_RUN, S_PLAY} st_e;

  localparam logic [1:0] LD_PROG = 2'd0;
  localparam logic [1:0] LD_PAT  = 2'd1;
  localparam logic [1:0] LD_TAB  = 2'd2;

  function automatic op_e op_of(input logic [INSTR_W-1:0] w);
    return op_e'(w[31:29]);
  endfunction

  function automatic logic [PNUM_W-1:0] pnum_of(input logic [INSTR_W-1:0] w);
    return w[28:22];
  endfunction

  function automatic logic [REP_W-1:0] rep_of(input logic [INSTR_W-1:0] w);
    return w[21:0];
  endfunction

  function automatic logic [TGT_W-1:0] tgt_of(input logic [INSTR_W-1:0] w);
    return w[9:0];
  endfunction

  // a pass count of zero runs the body once
  function automatic logic [REP_W-1:0] loop_init(input logic [REP_W-1:0] n);
    return (n == '0) ? REP_W'(1) : n;
  endfunction

  function automatic logic loop_again(input logic inf, input logic [REP_W-1:0] left);
    return inf || (left > REP_W'(1));
  endfunction
endpackage

// File: rtl/seq_trig_sync.sv
module seq_trig_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic s0, s1, s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0 <= 1'b0;
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else begin
      s0 <= din;
      s1 <= s0;
      s2 <= s1;
    end
  end

  assign rise = s1 & ~s2;
endmodule

// File: rtl/seq_lifo.sv
module seq_lifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       push,
  input  logic                       pop,
  input  logic                       wr_top,
  input  logic [W-1:0]               din,
  output logic [W-1:0]               top,
  output logic                       empty,
  output logic                       full,
  output logic [$clog2(DEPTH+1)-1:0] depth
);
  localparam int PW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] sp;
  logic [IW-1:0] top_idx, push_idx;

  assign empty    = (sp == '0);
  assign full     = (sp == PW'(DEPTH));
  assign depth    = sp;
  assign top_idx  = IW'(sp - 1'b1);
  assign push_idx = IW'(sp);
  assign top      = empty ? '0 : mem[top_idx];

  always_ff @(posedge clk) begin
    if (!clr) begin
      if (push && !full)
        mem[push_idx] <= din;
      else if (!pop && wr_top && !empty)
        mem[top_idx] <= din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sp <= '0;
    else if (clr)
      sp <= '0;
    else if (push && !full)
      sp <= sp + 1'b1;
    else if (pop && !empty)
      sp <= sp - 1'b1;
  end
endmodule

// File: rtl/seq_player.sv
module seq_player #(
  parameter int OUT_W  = 16,
  parameter int CTL_W  = 4,
  parameter int DUR_W  = 16,
  parameter int PAT_AW = 8,
  parameter int REP_W  = 22
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            go,
  input  logic                            kill,
  input  logic [PAT_AW-1:0]               base,
  input  logic [REP_W-1:0]                reps,
  output logic [PAT_AW-1:0]               rd_addr,
  input  logic [CTL_W+OUT_W+DUR_W:0]      rd_ent,
  output logic [OUT_W-1:0]                lines,
  output logic [CTL_W-1:0]                ctl,
  output logic                            boundary,
  output logic                            done
);
  localparam int ENT_W = 1 + CTL_W + OUT_W + DUR_W;

  function automatic logic [DUR_W-1:0] last_tick(input logic [DUR_W-1:0] d);
    return (d == '0) ? '0 : d - 1'b1;
  endfunction

  logic              act, fresh, cur_eop;
  logic [PAT_AW-1:0] addr, base_q;
  logic [DUR_W-1:0]  left;
  logic [REP_W-1:0]  rep_left;
  logic              step_end, last_rep, load;
  logic              ent_eop;
  logic [CTL_W-1:0]  ent_ctl;
  logic [OUT_W-1:0]  ent_lines;
  logic [DUR_W-1:0]  ent_dur;

  assign ent_eop   = rd_ent[ENT_W-1];
  assign ent_ctl   = rd_ent[ENT_W-2 -: CTL_W];
  assign ent_lines = rd_ent[DUR_W +: OUT_W];
  assign ent_dur   = rd_ent[DUR_W-1:0];

  assign step_end = act & ~fresh & (left == '0);
  assign last_rep = (rep_left == REP_W'(1));
  assign boundary = step_end & cur_eop;
  assign done     = boundary & last_rep;
  assign load     = act & (fresh | (step_end & ~(cur_eop & (last_rep | kill))));
  assign rd_addr  = fresh ? addr : (cur_eop ? base_q : addr + 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act      <= 1'b0;
      fresh    <= 1'b0;
      cur_eop  <= 1'b0;
      addr     <= '0;
      base_q   <= '0;
      left     <= '0;
      rep_left <= '0;
      lines    <= '0;
      ctl      <= '0;
    end else if (go) begin
      act      <= 1'b1;
      fresh    <= 1'b1;
      cur_eop  <= 1'b0;
      addr     <= base;
      base_q   <= base;
      left     <= '0;
      rep_left <= reps;
    end else if (act) begin
      if (load) begin
        lines   <= ent_lines;
        ctl     <= ent_ctl;
        left    <= last_tick(ent_dur);
        cur_eop <= ent_eop;
        addr    <= rd_addr;
        fresh   <= 1'b0;
        if (boundary) rep_left <= rep_left - 1'b1;
      end else if (boundary) begin
        act <= 1'b0;
      end else if (left != '0) begin
        left <= left - 1'b1;
      end
    end
  end
endmodule

// File: rtl/seq_interp.sv
module seq_interp
  import seq_pkg::*;
#(
  parameter int OUT_W  = 16,
  parameter int CTL_W  = 4,
  parameter int DUR_W  = 16,
  parameter int PC_W   = 10,
  parameter int PAT_AW = 8,
  parameter int STK_D  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ld_we,
  input  logic [1:0]                 ld_sel,
  input  logic [PC_W-1:0]            ld_addr,
  input  logic [CTL_W+OUT_W+DUR_W:0] ld_data,
  input  logic                       start,
  input  logic                       abort,
  input  logic                       trig_en,
  input  logic                       trig_in,
  output logic [OUT_W-1:0]           clk_lines,
  output logic [CTL_W-1:0]           ctl_out,
  output logic                       busy,
  output logic                       err
);
  localparam int ENT_W  = 1 + CTL_W + OUT_W + DUR_W;
  localparam int PROG_D = 2 ** PC_W;
  localparam int PAT_D  = 2 ** PAT_AW;
  localparam int TAB_D  = 2 ** PNUM_W;
  localparam int LS_W   = 1 + PC_W + REP_W;
  localparam int DW     = $clog2(STK_D + 1);

  // storage filled through the load port
  logic [INSTR_W-1:0] prog_mem [PROG_D];
  logic [ENT_W-1:0]   pat_mem  [PAT_D];
  logic [PAT_AW-1:0]  tab_mem  [TAB_D];

  always_ff @(posedge clk) begin
    if (ld_we && ld_sel == LD_PROG) prog_mem[ld_addr] <= ld_data[INSTR_W-1:0];
    if (ld_we && ld_sel == LD_PAT)  pat_mem[ld_addr[PAT_AW-1:0]] <= ld_data;
    if (ld_we && ld_sel == LD_TAB)  tab_mem[ld_addr[PNUM_W-1:0]] <= ld_data[PAT_AW-1:0];
  end

  st_e              st;
  logic [PC_W-1:0]  pc, pc_nxt;
  logic             abort_q;
  logic [INSTR_W-1:0] ir;
  op_e              op;

  assign ir = prog_mem[pc];
  assign op = op_of(ir);

  // named internal events
  logic in_idle, in_wait, in_run, in_play;
  logic abort_now, dec, trig_rise;
  logic loop_ovf, loop_udf, call_ovf, call_udf, bad_op;
  logic ev_err, ev_stop, ev_abort_run, go_idle, exec_go;
  logic lend_ok, lend_back;
  logic p_boundary, p_done;

  assign in_idle   = (st == S_IDLE);
  assign in_wait   = (st == S_WAIT);
  assign in_run    = (st == S_RUN);
  assign in_play   = (st == S_PLAY);
  assign abort_now = abort | abort_q;
  assign dec       = in_run & ~abort_now;

  // loop stack: {endless, body address, passes left}
  logic [LS_W-1:0] l_din, l_top;
  logic            l_push, l_pop, l_wr, l_empty, l_full;
  logic [DW-1:0]   l_depth;
  logic            top_inf;
  logic [PC_W-1:0] top_body;
  logic [REP_W-1:0] top_left;

  assign top_inf  = l_top[LS_W-1];
  assign top_body = l_top[REP_W +: PC_W];
  assign top_left = l_top[REP_W-1:0];

  // call stack of return addresses
  logic [PC_W-1:0] c_top;
  logic            c_push, c_pop, c_empty, c_full;
  logic [DW-1:0]   c_depth;

  assign loop_ovf  = dec & (op == OP_LOOP || op == OP_LINF) & l_full;
  assign loop_udf  = dec & (op == OP_LEND) & l_empty;
  assign call_ovf  = dec & (op == OP_JSR) & c_full;
  assign call_udf  = dec & (op == OP_RET) & c_empty;
  assign bad_op    = dec & (op == OP_RSVD);
  assign ev_err    = loop_ovf | loop_udf | call_ovf | call_udf | bad_op;
  assign ev_stop   = dec & (op == OP_STOP);
  assign ev_abort_run = in_run & abort_now;
  assign exec_go   = dec & (op == OP_EXEC) & (rep_of(ir) != '0);

  assign l_push    = dec & (op == OP_LOOP || op == OP_LINF) & ~l_full;
  assign lend_ok   = dec & (op == OP_LEND) & ~l_empty;
  assign lend_back = lend_ok & loop_again(top_inf, top_left);
  assign l_pop     = lend_ok & ~lend_back;
  assign l_wr      = lend_back;
  assign l_din     = l_push ? {op == OP_LINF, pc + 1'b1, loop_init(rep_of(ir))}
                            : {top_inf, top_body, top_left - 1'b1};

  assign c_push    = dec & (op == OP_JSR) & ~c_full;
  assign c_pop     = dec & (op == OP_RET) & ~c_empty;

  assign go_idle   = (in_wait & abort_now) | ev_abort_run | ev_err | ev_stop |
                     (in_play & p_boundary & abort_now);

  always_comb begin
    pc_nxt = pc + 1'b1;
    case (op)
      OP_LEND: if (lend_back) pc_nxt = top_body;
      OP_JSR:  pc_nxt = PC_W'(tgt_of(ir));
      OP_RET:  pc_nxt = c_top;
      default: ;
    endcase
  end

  seq_lifo #(.W(LS_W), .DEPTH(STK_D)) u_lstk (
    .clk(clk), .rst_n(rst_n), .clr(in_idle & start),
    .push(l_push), .pop(l_pop), .wr_top(l_wr), .din(l_din),
    .top(l_top), .empty(l_empty), .full(l_full), .depth(l_depth)
  );

  seq_lifo #(.W(PC_W), .DEPTH(STK_D)) u_cstk (
    .clk(clk), .rst_n(rst_n), .clr(in_idle & start),
    .push(c_push), .pop(c_pop), .wr_top(1'b0), .din(pc + 1'b1),
    .top(c_top), .empty(c_empty), .full(c_full), .depth(c_depth)
  );

  seq_trig_sync u_trig (
    .clk(clk), .rst_n(rst_n), .din(trig_in), .rise(trig_rise)
  );

  logic [PAT_AW-1:0] p_rd_addr;

  seq_player #(
    .OUT_W(OUT_W), .CTL_W(CTL_W), .DUR_W(DUR_W), .PAT_AW(PAT_AW), .REP_W(REP_W)
  ) u_play (
    .clk(clk), .rst_n(rst_n), .go(exec_go), .kill(in_play & abort_now),
    .base(tab_mem[pnum_of(ir)]), .reps(rep_of(ir)),
    .rd_addr(p_rd_addr), .rd_ent(pat_mem[p_rd_addr]),
    .lines(clk_lines), .ctl(ctl_out), .boundary(p_boundary), .done(p_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      pc      <= '0;
      err     <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      if (go_idle)
        abort_q <= 1'b0;
      else if (abort && !in_idle)
        abort_q <= 1'b1;

      case (st)
        S_IDLE: if (start) begin
          pc      <= '0;
          err     <= 1'b0;
          abort_q <= 1'b0;
          st      <= trig_en ? S_WAIT : S_RUN;
        end
        S_WAIT: begin
          if (go_idle)        st <= S_IDLE;
          else if (trig_rise) st <= S_RUN;
        end
        S_RUN: begin
          if (go_idle) begin
            st <= S_IDLE;
            if (ev_err && !abort_now) err <= 1'b1;
          end else if (exec_go) begin
            st <= S_PLAY;
          end else begin
            pc <= pc_nxt;
          end
        end
        S_PLAY: begin
          if (go_idle) begin
            st <= S_IDLE;
          end else if (p_done) begin
            pc <= pc + 1'b1;
            st <= S_RUN;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy = ~in_idle;
endmodule

// File: rtl/seq_interp_chk.sv
module seq_interp_chk #(
  parameter int OUT_W = 16,
  parameter int STK_D = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       start,
  input logic                       busy,
  input logic                       err,
  input logic [OUT_W-1:0]           clk_lines,
  input logic                       go_idle,
  input logic                       ev_err,
  input logic                       in_play,
  input logic                       p_boundary,
  input logic                       abort_now,
  input logic [$clog2(STK_D+1)-1:0] l_depth,
  input logic [$clog2(STK_D+1)-1:0] c_depth
);
  p_start_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  p_stop_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    go_idle |=> !busy);

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(clk_lines));

  p_err_halt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_err && !abort_now) |=> (err && !busy));

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !start) |=> err);

  p_abort_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_play && p_boundary && abort_now) |=> !busy);

  p_depth_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (l_depth <= STK_D) && (c_depth <= STK_D));
endmodule

bind seq_interp seq_interp_chk #(.OUT_W(OUT_W), .STK_D(STK_D)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .err(err),
  .clk_lines(clk_lines), .go_idle(go_idle), .ev_err(ev_err),
  .in_play(in_play), .p_boundary(p_boundary), .abort_now(abort_now),
  .l_depth(l_depth), .c_depth(c_depth)
);

// File: tb/sim_seq_interp.sv
`timescale 1ns/1ps
module sim_seq_interp;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_we = 1'b0;
  logic [1:0]  ld_sel = '0;
  logic [9:0]  ld_addr = '0;
  logic [36:0] ld_data = '0;
  logic        start = 1'b0, abort = 1'b0, trig_en = 1'b0, trig_in = 1'b0;
  logic [15:0] clk_lines;
  logic [3:0]  ctl_out;
  logic        busy, err;

  always #5 clk = ~clk;

  seq_interp u0 (
    .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_sel(ld_sel), .ld_addr(ld_addr),
    .ld_data(ld_data), .start(start), .abort(abort), .trig_en(trig_en),
    .trig_in(trig_in), .clk_lines(clk_lines), .ctl_out(ctl_out),
    .busy(busy), .err(err)
  );

  int n_chk = 0, n_err = 0;
  bit fin = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard: expected (value, hold cycles); hold 0 = not timed
  logic [15:0] qv[$];
  int          qd[$];
  logic [15:0] prev = '0;
  int          run = 0;
  int          n1000 = 0, n0001 = 0;
  bit          seen100 = 1'b0;

  task automatic expect_item(input logic [15:0] v, input int d);
    qv.push_back(v);
    qd.push_back(d);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (clk_lines != prev) begin
        if (qv.size() > 0) begin
          logic [15:0] ev;
          int          ed;
          ev = qv.pop_front();
          ed = qd.pop_front();
          chk(prev == ev, "R2 state order", {16'h0, prev}, {16'h0, ev});
          if (ed != 0) chk(run == ed, "R3 hold cycles", run, ed);
        end
        if (clk_lines == 16'h1000) n1000++;
        if (clk_lines == 16'h0001) n0001++;
        if (clk_lines == 16'h0100) seen100 = 1'b1;
        prev = clk_lines;
        run  = 1;
      end else begin
        run++;
      end
    end
  end

  task automatic load(input logic [1:0] sel, input int a, input logic [36:0] d);
    @(negedge clk);
    ld_we = 1'b1; ld_sel = sel; ld_addr = 10'(a); ld_data = d;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic prog(input int a, input logic [31:0] w);
    load(2'd0, a, {5'd0, w});
  endtask

  task automatic pent(input int a, input bit eop, input logic [3:0] c,
                      input logic [15:0] v, input logic [15:0] d);
    load(2'd1, a, {eop, c, v, d});
  endtask

  function automatic logic [31:0] i_exec(input int p, input int n);
    return {3'b001, 7'(p), 22'(n)};
  endfunction
  function automatic logic [31:0] i_loop(input int n);
    return {3'b010, 7'd0, 22'(n)};
  endfunction
  function automatic logic [31:0] i_op(input logic [2:0] o, input int a);
    return {o, 19'd0, 10'(a)};
  endfunction

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
  endtask

  task automatic wait_idle(input int lim);
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && err == 1'b0 && clk_lines == 16'h0, "R8 reset state",
        {busy, err, clk_lines}, 0);

    // R12 patterns: P0@0, P1@4, P2@8, P3@12
    pent(0, 0, 4'h1, 16'h0001, 16'd3);
    pent(1, 1, 4'h1, 16'h0002, 16'd2);
    pent(4, 0, 4'h3, 16'h0010, 16'd0);
    pent(5, 0, 4'h3, 16'h0020, 16'd2);
    pent(6, 1, 4'h3, 16'h0030, 16'd1);
    pent(8, 1, 4'hA, 16'h0100, 16'd4);
    pent(12, 0, 4'h5, 16'h1000, 16'd1);
    pent(13, 1, 4'h5, 16'h2000, 16'd1);
    load(2'd2, 0, 37'd0);
    load(2'd2, 1, 37'd4);
    load(2'd2, 2, 37'd8);
    load(2'd2, 3, 37'd12);

    // mixed program: repeats, counted loop, call (R2 R3 R4 R7)
    prog(0, i_exec(0, 2));
    prog(1, i_loop(2));
    prog(2, i_exec(1, 1));
    prog(3, i_op(3'b011, 0));
    prog(4, i_op(3'b101, 10));
    prog(5, i_op(3'b000, 0));
    prog(10, i_exec(2, 1));
    prog(11, i_op(3'b110, 0));
    expect_item(16'h0000, 0);
    expect_item(16'h0001, 3);
    expect_item(16'h0002, 2);
    expect_item(16'h0001, 3);
    expect_item(16'h0002, 5);
    expect_item(16'h0010, 1);
    expect_item(16'h0020, 2);
    expect_item(16'h0030, 4);
    expect_item(16'h0010, 1);
    expect_item(16'h0020, 2);
    expect_item(16'h0030, 5);
    pulse(start);
    chk(busy == 1'b1, "R1 busy after start", busy, 1);
    repeat (6) @(negedge clk);
    pulse(start); // ignored while busy (R1)
    wait_idle(300);
    chk(busy == 1'b0, "R8 stop ends run", busy, 0);
    chk(clk_lines == 16'h0100, "R7 subroutine pattern last", clk_lines, 16'h0100);
    chk(ctl_out == 4'hA, "R12 control field", ctl_out, 4'hA);
    chk(qv.size() == 0, "R3 all states seen", qv.size(), 0);
    repeat (5) @(negedge clk);
    chk(clk_lines == 16'h0100 && err == 1'b0, "R8 outputs hold idle",
        clk_lines, 16'h0100);
    expect_item(16'h0100, 0);
    qv.delete(); qd.delete();

    // reserved opcode (R9)
    prog(0, 32'hE000_0000);
    pulse(start);
    wait_idle(20);
    chk(err == 1'b1 && busy == 1'b0, "R9 reserved opcode", {err, busy}, 2'b10);
    // return with nothing saved; start clears err (R1 R9)
    prog(0, i_op(3'b110, 0));
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(err == 1'b0, "R1 start clears err", err, 0);
    wait_idle(20);
    chk(err == 1'b1, "R9 return underflow", err, 1);

    // eight nested loops, counts include 0 (R4 R5)
    prog(0, i_loop(2)); prog(1, i_loop(0)); prog(2, i_loop(1)); prog(3, i_loop(1));
    prog(4, i_loop(1)); prog(5, i_loop(1)); prog(6, i_loop(1)); prog(7, i_loop(3));
    prog(8, i_exec(3, 1));
    for (int k = 9; k < 17; k++) prog(k, i_op(3'b011, 0));
    prog(17, i_op(3'b000, 0));
    n1000 = 0;
    pulse(start);
    wait_idle(2000);
    chk(n1000 == 6, "R4 R5 nested pass count", n1000, 6);
    chk(err == 1'b0 && busy == 1'b0, "R5 eight deep ok", {err, busy}, 0);
    // ninth nested loop overflows (R9)
    for (int k = 0; k < 9; k++) prog(k, i_loop(1));
    prog(9, i_op(3'b000, 0));
    pulse(start);
    wait_idle(40);
    chk(err == 1'b1, "R9 loop overflow", err, 1);

    // endless loop then abort (R6 R10)
    prog(0, i_op(3'b100, 0));
    prog(1, i_exec(0, 1));
    prog(2, i_op(3'b011, 0));
    prog(3, i_op(3'b000, 0));
    n0001 = 0;
    pulse(start);
    repeat (100) @(negedge clk);
    chk(busy == 1'b1 && n0001 >= 5, "R6 endless loop runs", n0001, 5);
    pulse(abort);
    wait_idle(20);
    chk(busy == 1'b0, "R10 abort ends run", busy, 0);
    chk(clk_lines == 16'h0002, "R10 ends on pattern boundary", clk_lines, 16'h0002);
    chk(err == 1'b0, "R10 abort is not an error", err, 0);

    // trigger gate and zero play count (R11 R2)
    prog(0, i_exec(2, 0));
    prog(1, i_exec(1, 1));
    prog(2, i_op(3'b000, 0));
    seen100 = 1'b0;
    trig_en = 1'b1;
    pulse(start);
    repeat (20) @(negedge clk);
    chk(busy == 1'b1 && clk_lines == 16'h0002, "R11 waits for trigger",
        clk_lines, 16'h0002);
    trig_in = 1'b1;
    wait_idle(60);
    chk(clk_lines == 16'h0030, "R11 runs after trigger", clk_lines, 16'h0030);
    chk(seen100 == 1'b0, "R2 zero play count skipped", seen100, 0);
    // abort while waiting (R10)
    trig_in = 1'b0;
    repeat (4) @(negedge clk);
    pulse(start);
    repeat (10) @(negedge clk);
    pulse(abort);
    repeat (2) @(negedge clk);
    chk(busy == 1'b0 && clk_lines == 16'h0030, "R10 abort in trigger wait",
        {busy, clk_lines}, 16'h0030);
    trig_en = 1'b0;

    fin = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog run did not end");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule